// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers interrupt requests organised as priority levels. Every level owns a wide pending vector, and a per-level activity bit records whether any request on that level is still outstanding. Requests are set and removed one at a time through post and clear commands, and a clear-all command wipes every level at once.

The controller merges the activity bits that fall in the external range with a software request word and produces one chosen priority. When that priority is above the processor's current priority level, and the other gating conditions hold, the block raises `irq_req`. Taking the interrupt records the chosen priority and a summary mask of every contributing source. A later update strobe then publishes the recorded pair on the identification and summary outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A post command (`cmd_op` = 2'b01) with an in-range level and index sets that pending bit and, at the next rising edge, sets bit `cmd_level` of `lvl_act`.
- R2: A clear command (`cmd_op` = 2'b10) removes one pending bit. The level's `lvl_act` bit drops at the next edge only if no other pending bit of that level remains.
- R3: A clear-all command (`cmd_op` = 2'b11) empties every level, so `lvl_act` reads zero after the next edge. The level and index inputs play no part in this command.
- R4: A post or clear whose level is at least NLEV, or whose index is at least VEC_W, changes no state. `cmd_err` is then high for exactly the cycle after the command.
- R5: `irq_req` is low whenever `lvl_act` is all zero, and whenever `pc_low` is nonzero, whatever the software request word holds.
- R6: Software bit i, with SW_LO <= i < SW_HI (default 4..11), maps to priority i-SW_LO+1. Active level i, with EXT_LO <= i < EXT_HI (default 20..31), maps to priority i. The highest such source wins, and any external source outranks every software source. Each contributing bit i sets bit i of the summary mask. Bits outside both ranges contribute nothing.
- R7: `irq_req` is high only when the chosen priority is nonzero and strictly greater than `cur_ipl`.
- R8: A `take` pulse while `irq_req` is high records the chosen priority and summary mask and sets `info_pend` at the next edge. A `take` pulse while `irq_req` is low has no effect.
- R9: An `upd` pulse while `info_pend` is set copies the recorded priority to `int_id` and the recorded mask to `int_sum` at the next edge, and clears `info_pend`.
- R10: An `upd` pulse while `info_pend` is clear leaves `int_id` and `int_sum` unchanged.
- R11: Synchronous reset clears all pending bits, `lvl_act`, `int_id`, `int_sum`, `info_pend` and `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 2 | 00 idle, 01 post, 10 clear, 11 clear-all |
| cmd_level | input | LVL_IN_W | Level addressed by post or clear |
| cmd_index | input | IDX_IN_W | Bit within the level's pending vector |
| sw_req | input | NLEV | Software request word |
| pc_low | input | 2 | Two low bits of the current program counter |
| cur_ipl | input | PRI_W | Current processor priority level |
| take | input | 1 | Interrupt accepted; record priority and mask |
| upd | input | 1 | Publish the recorded priority and mask |
| irq_req | output | 1 | Interrupt request, combinational |
| lvl_act | output | NLEV | Per-level activity bits |
| int_id | output | PRI_W | Published interrupt priority |
| int_sum | output | NLEV | Published summary mask |
| info_pend | output | 1 | A recorded pair is waiting for `upd` |
| cmd_err | output | 1 | One-cycle pulse after an out-of-range command |

## Verification
The bench posts two requests on one level and clears them one at a time. A design that drops the activity bit on the first clear, instead of waiting for the vector to empty, fails there. It raises a software request while an external level is active and checks the published priority. A scan in the wrong order or with the wrong mapping yields a software priority there. It places `cur_ipl` equal to and one below the chosen priority to catch a non-strict compare. It also sends `upd` with no recorded pair, `take` while the request is low, and commands one past the level and index limits, each of which a careless design lets through as a state change.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLEV     = 32,
  parameter int VEC_W    = 64,
  parameter int SW_LO    = 4,
  parameter int SW_HI    = 12,
  parameter int EXT_LO   = 20,
  parameter int EXT_HI   = 32,
  parameter int LVL_IN_W = 8,
  parameter int IDX_IN_W = 8,
  parameter int PRI_W    = $clog2(NLEV)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cmd_op,
  input  logic [LVL_IN_W-1:0] cmd_level,
  input  logic [IDX_IN_W-1:0] cmd_index,
  input  logic [NLEV-1:0]     sw_req,
  input  logic [1:0]          pc_low,
  input  logic [PRI_W-1:0]    cur_ipl,
  input  logic                take,
  input  logic                upd,
  output logic                irq_req,
  output logic [NLEV-1:0]     lvl_act,
  output logic [PRI_W-1:0]    int_id,
  output logic [NLEV-1:0]     int_sum,
  output logic                info_pend,
  output logic                cmd_err
);
  localparam int LW = $clog2(NLEV);
  localparam int IW = $clog2(VEC_W);
  localparam logic [1:0] OP_POST = 2'b01, OP_CLR = 2'b10, OP_ALL = 2'b11;

  logic [VEC_W-1:0] pend [NLEV];
  logic [PRI_W-1:0] chosen, lat_pri;
  logic [NLEV-1:0]  summ, lat_sum;
  logic [VEC_W-1:0] after_clr;

  wire is_addr = (cmd_op == OP_POST) || (cmd_op == OP_CLR);
  wire bad     = is_addr && ((int'(cmd_level) >= NLEV) || (int'(cmd_index) >= VEC_W));
  wire ok      = is_addr && !bad;
  wire [LW-1:0] lvl = cmd_level[LW-1:0];
  wire [IW-1:0] idx = cmd_index[IW-1:0];

  assign after_clr = pend[lvl] & ~(VEC_W'(1) << idx);

  always_comb begin
    chosen = '0;
    summ   = '0;
    for (int i = SW_LO; i < SW_HI; i++)
      if (sw_req[i]) begin
        chosen  = PRI_W'(i - SW_LO + 1);
        summ[i] = 1'b1;
      end
    for (int i = EXT_LO; i < EXT_HI; i++)
      if (lvl_act[i]) begin
        chosen  = PRI_W'(i);
        summ[i] = 1'b1;
      end
  end

  assign irq_req = (|lvl_act) && (pc_low == 2'b00) && (chosen != '0) && (chosen > cur_ipl);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NLEV; l++) pend[l] <= '0;
      lvl_act   <= '0;
      cmd_err   <= 1'b0;
      lat_pri   <= '0;
      lat_sum   <= '0;
      info_pend <= 1'b0;
      int_id    <= '0;
      int_sum   <= '0;
    end else begin
      cmd_err <= bad;
      if (ok && cmd_op == OP_POST) begin
        pend[lvl][idx] <= 1'b1;
        lvl_act[lvl]   <= 1'b1;
      end else if (ok && cmd_op == OP_CLR) begin
        pend[lvl][idx] <= 1'b0;
        if (after_clr == '0) lvl_act[lvl] <= 1'b0;
      end else if (cmd_op == OP_ALL) begin
        for (int l = 0; l < NLEV; l++) pend[l] <= '0;
        lvl_act <= '0;
      end
      if (upd && info_pend) begin
        int_id    <= lat_pri;
        int_sum   <= lat_sum;
        info_pend <= 1'b0;
      end
      if (take && irq_req) begin
        lat_pri   <= chosen;
        lat_sum   <= summ;
        info_pend <= 1'b1;
      end
    end
  end

  assert_post_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (ok && cmd_op == OP_POST) |=> lvl_act[$past(lvl)]);

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_ALL) |=> (lvl_act == '0 && !irq_req));

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    bad |=> (cmd_err && $stable(lvl_act)));

  assert_pc_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_low != 2'b00 || lvl_act == '0) |-> !irq_req);

  assert_commit_R9: assert property (@(posedge clk) disable iff (rst)
    (upd && info_pend && !(take && irq_req)) |=> !info_pend);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (upd && !info_pend) |=> ($stable(int_id) && $stable(int_sum)));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_level = '0;
  logic [7:0]  cmd_index = '0;
  logic [31:0] sw_req = '0;
  logic [1:0]  pc_low = '0;
  logic [4:0]  cur_ipl = '0;
  logic        take = 1'b0;
  logic        upd = 1'b0;
  logic        irq_req, info_pend, cmd_err;
  logic [31:0] lvl_act, int_sum;
  logic [4:0]  int_id;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_level(cmd_level), .cmd_index(cmd_index),
    .sw_req(sw_req), .pc_low(pc_low), .cur_ipl(cur_ipl), .take(take), .upd(upd),
    .irq_req(irq_req), .lvl_act(lvl_act), .int_id(int_id), .int_sum(int_sum),
    .info_pend(info_pend), .cmd_err(cmd_err));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] op, int l, int i);
    @(negedge clk);
    cmd_op = op; cmd_level = 8'(l); cmd_index = 8'(i);
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic pulse_take();
    @(negedge clk); take = 1'b1;
    @(negedge clk); take = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 lvl_act", lvl_act, 0);
    chk("R11 int_id", int_id, 0);
    chk("R11 int_sum", int_sum, 0);
    chk("R11 info_pend", info_pend, 0);
    chk("R11 cmd_err", cmd_err, 0);
    chk("R11 irq_req", irq_req, 0);
  endtask

  task automatic t_software();
    sw_req = 32'h0000_0220; #1;
    chk("R5 no irq with empty status", irq_req, 0);
    cmd(2'b01, 3, 7);
    chk("R1 post level 3", lvl_act, 32'h8);
    chk("R6 software priority raises irq", irq_req, 1);
    pc_low = 2'b01; #1;
    chk("R5 pc gate", irq_req, 0);
    pc_low = 2'b00; cur_ipl = 5'd6; #1;
    chk("R7 equal ipl blocks", irq_req, 0);
    cur_ipl = 5'd5; #1;
    chk("R7 lower ipl passes", irq_req, 1);
    cur_ipl = 5'd0;
    pulse_take();
    chk("R8 take sets info_pend", info_pend, 1);
    chk("R8 int_id before update", int_id, 0);
    pulse_upd();
    chk("R9 int_id sw priority", int_id, 6);
    chk("R9 int_sum sw mask", int_sum, 32'h220);
    chk("R9 flag cleared", info_pend, 0);
  endtask

  task automatic t_no_info();
    sw_req = 32'h0000_0010;
    pulse_upd();
    chk("R10 int_id held", int_id, 6);
    chk("R10 int_sum held", int_sum, 32'h220);
    sw_req = 32'h0000_0220;
  endtask

  task automatic t_external();
    cmd(2'b01, 22, 0);
    cmd(2'b01, 25, 63);
    chk("R1 two external posts", lvl_act, 32'h0240_0008);
    cur_ipl = 5'd25; #1;
    chk("R7 ext equal blocks", irq_req, 0);
    cur_ipl = 5'd24; #1;
    chk("R7 ext above passes", irq_req, 1);
    cur_ipl = 5'd0;
    pulse_take();
    pulse_upd();
    chk("R6 external overrides software", int_id, 25);
    chk("R6 merged summary", int_sum, 32'h0240_0220);
  endtask

  task automatic t_clear();
    cmd(2'b01, 25, 1);
    cmd(2'b10, 25, 63);
    chk("R2 level stays while bits remain", lvl_act, 32'h0240_0008);
    cmd(2'b10, 25, 1);
    chk("R2 level drops when empty", lvl_act, 32'h0040_0008);
  endtask

  task automatic t_range();
    @(negedge clk);
    cmd_op = 2'b01; cmd_level = 8'd32; cmd_index = 8'd0;
    @(negedge clk);
    cmd_op = 2'b00;
    chk("R4 bad level err", cmd_err, 1);
    chk("R4 bad level ignored", lvl_act, 32'h0040_0008);
    @(negedge clk);
    chk("R4 err one cycle", cmd_err, 0);
    cmd(2'b01, 1, 64);
    chk("R4 bad index err", cmd_err, 1);
    chk("R4 bad index ignored", lvl_act, 32'h0040_0008);
    cmd(2'b10, 22, 64);
    chk("R4 bad clear ignored", lvl_act, 32'h0040_0008);
  endtask

  task automatic t_take_ignored();
    pc_low = 2'b10;
    pulse_take();
    chk("R8 take ignored without irq", info_pend, 0);
    pulse_upd();
    chk("R8 int_id untouched", int_id, 25);
    pc_low = 2'b00;
  endtask

  task automatic t_clear_all();
    cmd(2'b11, 200, 200);
    chk("R3 clear-all", lvl_act, 0);
    chk("R3 irq low after clear-all", irq_req, 0);
    chk("R3 no err on clear-all", cmd_err, 0);
  endtask

  task automatic t_reset_mid();
    cmd(2'b01, 22, 5);
    pulse_take();
    chk("R8 pending before reset", info_pend, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_software();
    t_no_info();
    t_external();
    t_clear();
    t_range();
    t_take_ignored();
    t_clear_all();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule